// File: doc/BRIEF.md
# Chunked EEPROM Write Sequencer

This block writes a run of bytes into a small serial EEPROM whose memory offset is carried in the address byte of every bus transaction. A request names a start offset and a length of up to 256 bytes. The block cuts the run into bus transactions of at most four bytes, and between transactions it waits for the device to finish its internal programming cycle by polling it. It fetches the bytes to write over a valid/ready stream and ends every request with a one-cycle `done_o`, qualified by `error_o`.

The block does not drive the bus pins. It issues byte-level operations to a bit engine (recover, start, stop, write byte, read byte) and receives one completion pulse per operation, carrying the acknowledge seen on the bus. The first non-empty request after reset runs the bus-recovery operation once before any transaction.

Top module: `eeprom_chunk_writer`

## Requirements
- R1: A request with length 0 raises `done_o` in the next cycle with `error_o` low, issues no operation to the bit engine and fetches no data.
- R2: The first non-empty request after reset begins with exactly one recover operation (code 0); no later request issues it again.
- R3: Each transaction is start (code 1), a write (code 3) of the address byte {offset[6:0], 1'b0}, its data bytes, and stop (code 2). A transaction holds min(remaining, 4) bytes and the offset advances by that count, modulo 128.
- R4: Data bytes are written in the order they were accepted on the stream (accepted when `wdata_valid_i` and `wdata_ready_o` are both high), and a completed request accepts exactly `len_i` bytes.
- R5: While no data byte is buffered the block stalls and presents no data write operation.
- R6: If the address byte or a data byte is not acknowledged, the block issues one stop and ends the request with `error_o`; no further byte of the request is written.
- R7: After each transaction the block polls: start, write of byte 0x01 (read command to offset 0); if that write is not acknowledged it issues stop and polls again.
- R8: An acknowledged poll is followed by one read byte operation (code 4, no master acknowledge, the byte is discarded) and a stop; the block then starts the next transaction or finishes.
- R9: After POLL_MAX unacknowledged polls in a row (100 by default), each with its stop, the request ends with `error_o`.
- R10: `done_o` is a one-cycle pulse in the cycle after the completion of the request's last operation, `error_o` is high only together with `done_o`, and no operation is presented while `done_o` is high.
- R11: An operation, once presented, keeps its code and byte until `op_done_i`.
- R12: `start_i` is ignored while a request is in progress; when idle no operation is presented and no data is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when idle |
| offset_i | input | 7 | First EEPROM offset |
| len_i | input | 9 | Number of bytes to write, 0 to 256 |
| wdata_valid_i | input | 1 | Data byte valid |
| wdata_i | input | 8 | Data byte |
| wdata_ready_o | output | 1 | Block can take a data byte |
| op_valid_o | output | 1 | Operation presented to the bit engine |
| op_code_o | output | 3 | 0 recover, 1 start, 2 stop, 3 write byte, 4 read byte |
| op_byte_o | output | 8 | Byte for a write operation |
| op_done_i | input | 1 | One-cycle completion of the presented operation |
| op_ack_i | input | 1 | Acknowledge seen for a write, valid with `op_done_i` |
| done_o | output | 1 | Request finished, one cycle |
| error_o | output | 1 | Request failed, valid with `done_o` |

## Verification
Lengths of 1, 6 (starting at offset 126 so the offset wraps), 9 and 256 separate correct chunk sizing and offset stepping from off-by-one splits, and a zero length before any other request shows that recovery is tied to the first real access. Sparse data validity against varied engine latency tells a prefetching stall apart from writing a stale byte. Polls answered after zero, one and two refusals, refusals on an address byte and on a data byte, and a device that never answers distinguish the abort path, the retry path and the poll limit.

// File: rtl/ewr_pkg.sv
package ewr_pkg;
  typedef enum logic [2:0] {
    OP_RECOVER = 3'd0,
    OP_START   = 3'd1,
    OP_STOP    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_READ    = 3'd4
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RECOVER, S_START, S_CMD, S_DWAIT, S_DATA, S_STOP,
    S_PSTART, S_PCMD, S_PSTOP, S_PREAD, S_FSTOP, S_ASTOP, S_DONE
  } seq_state_e;
endpackage

// File: rtl/ewr_prefetch.sv
module ewr_prefetch #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              clear_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  input  logic              take_i,
  output logic              have_o,
  output logic [DATA_W-1:0] byte_o
);
  logic [LEN_W-1:0]  left_q;
  logic              full_q;
  logic [DATA_W-1:0] buf_q;

  assign ready_o = !full_q && (left_q != '0);
  assign have_o  = full_q;
  assign byte_o  = buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      full_q <= 1'b0;
      buf_q  <= '0;
    end else if (load_i) begin
      left_q <= len_i;
      full_q <= 1'b0;
    end else if (clear_i) begin
      left_q <= '0;
      full_q <= 1'b0;
    end else if (valid_i && ready_o) begin
      buf_q  <= data_i;
      full_q <= 1'b1;
      left_q <= left_q - 1'b1;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ewr_addr_track.sv
module ewr_addr_track #(
  parameter int OFS_W = 7,
  parameter int LEN_W = 9,
  parameter int CHUNK = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             chunk_i,
  input  logic             sent_i,
  output logic [OFS_W:0]   cmd_byte_o,
  output logic             last_o,
  output logic             empty_o
);
  localparam int CW = $clog2(CHUNK + 1);

  logic [OFS_W-1:0] ofs_q;
  logic [LEN_W-1:0] rem_q;
  logic [CW-1:0]    left_q;
  logic [CW-1:0]    chunk_size;

  assign chunk_size = (rem_q > LEN_W'(CHUNK)) ? CW'(CHUNK) : rem_q[CW-1:0];
  assign cmd_byte_o = {ofs_q, 1'b0};
  assign last_o     = (left_q == CW'(1));
  assign empty_o    = (rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q  <= '0;
      rem_q  <= '0;
      left_q <= '0;
    end else if (load_i) begin
      ofs_q  <= ofs_i;
      rem_q  <= len_i;
      left_q <= '0;
    end else if (chunk_i) begin
      left_q <= chunk_size;
    end else if (sent_i) begin
      ofs_q  <= ofs_q + 1'b1;
      rem_q  <= rem_q - 1'b1;
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/ewr_poll_ctr.sv
module ewr_poll_ctr #(
  parameter int POLL_MAX = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic miss_i,
  output logic hit_o
);
  localparam int PW = $clog2(POLL_MAX + 1);

  logic [PW-1:0] cnt_q;

  assign hit_o = (cnt_q == PW'(POLL_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (miss_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/eeprom_chunk_writer.sv
module eeprom_chunk_writer
  import ewr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LEN_W    = 9,
  parameter int CHUNK    = 4,
  parameter int POLL_MAX = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-2:0] offset_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              wdata_valid_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              wdata_ready_o,
  output logic              op_valid_o,
  output logic [2:0]        op_code_o,
  output logic [DATA_W-1:0] op_byte_o,
  input  logic              op_done_i,
  input  logic              op_ack_i,
  output logic              done_o,
  output logic              error_o
);
  localparam int OFS_W = DATA_W - 1;
  localparam logic [DATA_W-1:0] POLL_BYTE = {{(DATA_W-1){1'b0}}, 1'b1};

  seq_state_e        st_q, st_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              err_q, err_d;
  logic              init_q, init_d;
  logic              ld, chunk_go, sent, take, p_clr, p_miss;
  logic              have, last, empty, p_hit;
  logic [DATA_W-1:0] pf_byte, cmd_byte;
  logic              busy;

  ewr_prefetch #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_prefetch (
    .clk_i, .rst_ni,
    .load_i (ld),
    .len_i,
    .clear_i(st_q == S_DONE),
    .valid_i(wdata_valid_i),
    .data_i (wdata_i),
    .ready_o(wdata_ready_o),
    .take_i (take),
    .have_o (have),
    .byte_o (pf_byte)
  );

  ewr_addr_track #(.OFS_W(OFS_W), .LEN_W(LEN_W), .CHUNK(CHUNK)) i_addr (
    .clk_i, .rst_ni,
    .load_i    (ld),
    .ofs_i     (offset_i),
    .len_i,
    .chunk_i   (chunk_go),
    .sent_i    (sent),
    .cmd_byte_o(cmd_byte),
    .last_o    (last),
    .empty_o   (empty)
  );

  ewr_poll_ctr #(.POLL_MAX(POLL_MAX)) i_poll (
    .clk_i, .rst_ni,
    .clear_i(p_clr),
    .miss_i (p_miss),
    .hit_o  (p_hit)
  );

  always_comb begin
    st_d     = st_q;
    byte_d   = byte_q;
    err_d    = err_q;
    init_d   = init_q;
    ld       = 1'b0;
    chunk_go = 1'b0;
    sent     = 1'b0;
    take     = 1'b0;
    p_clr    = 1'b0;
    p_miss   = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        ld    = 1'b1;
        err_d = 1'b0;
        if (len_i == '0)  st_d = S_DONE;
        else if (!init_q) st_d = S_RECOVER;
        else              st_d = S_START;
      end
      S_RECOVER: if (op_done_i) begin
        init_d = 1'b1;
        st_d   = S_START;
      end
      S_START: if (op_done_i) begin
        chunk_go = 1'b1;
        byte_d   = cmd_byte;
        st_d     = S_CMD;
      end
      S_CMD: if (op_done_i) begin
        if (!op_ack_i) st_d = S_ASTOP;
        else if (have) begin
          take   = 1'b1;
          byte_d = pf_byte;
          st_d   = S_DATA;
        end else st_d = S_DWAIT;
      end
      S_DWAIT: if (have) begin
        take   = 1'b1;
        byte_d = pf_byte;
        st_d   = S_DATA;
      end
      S_DATA: if (op_done_i) begin
        if (!op_ack_i) st_d = S_ASTOP;
        else begin
          sent = 1'b1;
          if (last) st_d = S_STOP;
          else if (have) begin
            take   = 1'b1;
            byte_d = pf_byte;
          end else st_d = S_DWAIT;
        end
      end
      S_STOP: if (op_done_i) begin
        p_clr = 1'b1;
        st_d  = S_PSTART;
      end
      S_PSTART: if (op_done_i) begin
        byte_d = POLL_BYTE;
        st_d   = S_PCMD;
      end
      S_PCMD: if (op_done_i) begin
        if (op_ack_i) st_d = S_PREAD;
        else begin
          p_miss = 1'b1;
          st_d   = S_PSTOP;
        end
      end
      S_PSTOP: if (op_done_i) begin
        if (p_hit) begin
          err_d = 1'b1;
          st_d  = S_DONE;
        end else st_d = S_PSTART;
      end
      S_PREAD: if (op_done_i) st_d = S_FSTOP;
      S_FSTOP: if (op_done_i) st_d = empty ? S_DONE : S_START;
      S_ASTOP: if (op_done_i) begin
        err_d = 1'b1;
        st_d  = S_DONE;
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      byte_q <= '0;
      err_q  <= 1'b0;
      init_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      byte_q <= byte_d;
      err_q  <= err_d;
      init_q <= init_d;
    end
  end

  always_comb begin
    op_code_o = OP_STOP;
    unique case (st_q)
      S_RECOVER:               op_code_o = OP_RECOVER;
      S_START, S_PSTART:       op_code_o = OP_START;
      S_CMD, S_DATA, S_PCMD:   op_code_o = OP_WRITE;
      S_PREAD:                 op_code_o = OP_READ;
      default:                 op_code_o = OP_STOP;
    endcase
  end

  assign op_valid_o = !(st_q inside {S_IDLE, S_DWAIT, S_DONE});
  assign op_byte_o  = byte_q;
  assign done_o     = (st_q == S_DONE);
  assign error_o    = done_o && err_q;
  assign busy       = (st_q != S_IDLE);
endmodule

// File: rtl/ewr_checker.sv
module ewr_checker #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [LEN_W-1:0]  len_i,
  input logic              op_valid_o,
  input logic [2:0]        op_code_o,
  input logic [DATA_W-1:0] op_byte_o,
  input logic              op_done_i,
  input logic              wdata_ready_o,
  input logic              done_o,
  input logic              error_o,
  input logic              busy_i
);
  assert_zero_len_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && start_i && len_i == '0) |=> (done_o && !error_o));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_error_qual_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> done_o);

  assert_done_no_op_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !op_valid_o);

  assert_op_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && !op_done_i) |=> (op_valid_o && $stable(op_code_o) && $stable(op_byte_o)));

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!op_valid_o && !wdata_ready_o));
endmodule

bind eeprom_chunk_writer ewr_checker #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_ewr_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .len_i        (len_i),
  .op_valid_o   (op_valid_o),
  .op_code_o    (op_code_o),
  .op_byte_o    (op_byte_o),
  .op_done_i    (op_done_i),
  .wdata_ready_o(wdata_ready_o),
  .done_o       (done_o),
  .error_o      (error_o),
  .busy_i       (busy)
);

// File: tb/test_eeprom_chunk_writer.sv
module test_eeprom_chunk_writer;
  localparam int POLL_MAX = 100;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [6:0] offset_i = '0;
  logic [8:0] len_i = '0;
  logic       wdata_valid_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       wdata_ready_o;
  logic       op_valid_o;
  logic [2:0] op_code_o;
  logic [7:0] op_byte_o;
  logic       op_done_i = 1'b0;
  logic       op_ack_i = 1'b0;
  logic       done_o;
  logic       error_o;

  eeprom_chunk_writer #(.POLL_MAX(POLL_MAX)) i_eeprom_chunk_writer (.*);

  always #10 clk_i = ~clk_i;

  int total = 0, bad = 0;
  int q_code[$], q_byte[$], q_ack[$];
  string q_tag[$];
  int np;
  bit exp_err, bench_init = 0;
  bit run_active = 0, seen_err = 0, fin_next = 0, zero_next = 0;
  string run_tag = "R10";
  logic [7:0] src_mem [256];
  int src_len = 0, src_ptr = 0, gap = 0, lat = 1, cyc = 0;
  bit hs_pending = 0;
  bit eng_busy = 0, cur_ack = 1, cur_last = 0;
  int eng_cnt = 0;

  task automatic chk(bit c, string tag, string what, int act, int exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(int code, int b, bit ack, string tag);
    q_code.push_back(code);
    q_byte.push_back(b);
    q_ack.push_back(ack);
    q_tag.push_back(tag);
    np++;
  endtask

  // expected operation stream, built from the requirements
  task automatic build(int ofs, int len, int pn, int nk);
    int rem = len, o = ofs, pos = 0, n;
    bit ab = 0, ok;
    np = 0;
    exp_err = 0;
    if (len == 0) return;
    if (!bench_init) begin push(0, 0, 1, "R2"); bench_init = 1; end
    while (rem > 0 && !ab) begin
      n = (rem > 4) ? 4 : rem;
      push(1, 0, 1, "R3");
      ok = (np != nk);
      push(3, (o << 1) & 255, ok, "R3");
      if (!ok) begin push(2, 0, 1, "R6"); exp_err = 1; break; end
      for (int k = 0; k < n; k++) begin
        ok = (np != nk);
        push(3, src_mem[pos], ok, "R4");
        pos++;
        if (!ok) begin ab = 1; break; end
      end
      if (ab) begin push(2, 0, 1, "R6"); exp_err = 1; break; end
      push(2, 0, 1, "R3");
      o = (o + n) % 128;
      rem -= n;
      for (int a = 0; ; a++) begin
        push(1, 0, 1, "R7");
        ok = (a >= pn);
        push(3, 1, ok, "R7");
        if (ok) begin push(4, 0, 1, "R8"); push(2, 0, 1, "R8"); break; end
        push(2, 0, 1, "R7");
        if (a + 1 == POLL_MAX) begin exp_err = 1; ab = 1; break; end
      end
    end
  endtask

  // per-clock comparison, bit engine model and data source
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      chk(done_o == (fin_next | zero_next), "R10", "done_o timing", done_o, fin_next | zero_next);
      chk(error_o == ((fin_next | zero_next) & exp_err & !zero_next), run_tag, "error_o",
          error_o, (fin_next | zero_next) & exp_err & !zero_next);
      if (done_o) begin seen_err = error_o; run_active = 0; end
      fin_next = 0;
      zero_next = 0;

      if (op_done_i) begin op_done_i = 0; eng_busy = 0; end
      if (!eng_busy && op_valid_o) begin
        if (q_code.size() == 0) begin
          chk(0, "R12", "unexpected op code", op_code_o, -1);
          cur_ack = 1; cur_last = 0;
        end else begin
          chk(op_code_o == q_code[0], q_tag[0], "op code", op_code_o, q_code[0]);
          if (q_code[0] == 3)
            chk(op_byte_o == q_byte[0], q_tag[0], "op byte", op_byte_o, q_byte[0]);
          cur_ack = q_ack[0];
          void'(q_code.pop_front()); void'(q_byte.pop_front());
          void'(q_ack.pop_front());  void'(q_tag.pop_front());
          cur_last = (q_code.size() == 0);
        end
        eng_busy = 1;
        eng_cnt = lat;
      end else if (eng_busy) begin
        eng_cnt--;
        if (eng_cnt == 0) begin
          op_done_i = 1;
          op_ack_i = cur_ack;
          if (cur_last && run_active) fin_next = 1;
        end
      end

      if (hs_pending) src_ptr++;
      wdata_valid_i = (src_ptr < src_len) && (gap == 0 || (cyc % gap) == 0);
      wdata_i = src_mem[src_ptr[7:0]];
      #1;
      hs_pending = wdata_valid_i && wdata_ready_o;
    end
  end

  task automatic do_run(string tag, int ofs, int len, int pn, int nk, int lat_v, int gap_v, bit mid);
    @(negedge clk_i); #3;
    for (int i = 0; i < 256; i++) src_mem[i] = 8'((i * 29 + ofs * 7 + len) & 255);
    src_len = len; src_ptr = 0; hs_pending = 0;
    lat = lat_v; gap = gap_v; run_tag = tag;
    build(ofs, len, pn, nk);
    run_active = 1;
    start_i = 1; offset_i = 7'(ofs); len_i = 9'(len);
    if (len == 0) zero_next = 1;
    @(negedge clk_i); #3;
    start_i = 0;
    if (mid) begin
      repeat (5) @(negedge clk_i);
      #3 start_i = 1; len_i = 9'd3; offset_i = '0;
      @(negedge clk_i); #3 start_i = 0;
    end
    while (run_active) @(negedge clk_i);
    chk(q_code.size() == 0, tag, "ops still expected", q_code.size(), 0);
    chk(seen_err == exp_err, tag, "final error", seen_err, exp_err);
    if (!exp_err) chk(src_ptr == len, "R4", "bytes accepted", src_ptr, len);
    else          chk(src_ptr <= len, "R6", "bytes accepted", src_ptr, len);
    repeat (2) @(negedge clk_i);
    #3 chk(!op_valid_o && !wdata_ready_o && !done_o, "R12", "idle outputs",
           {op_valid_o, wdata_ready_o, done_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #3 chk(!done_o && !error_o && !op_valid_o && !wdata_ready_o, "R12", "reset outputs",
           {done_o, error_o, op_valid_o, wdata_ready_o}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    do_run("R1",  0,   0,   0, -1, 1, 0, 0);   // zero length, before any recovery
    do_run("R2",  5,   1,   0, -1, 2, 0, 0);   // first real access recovers
    do_run("R3",  126, 6,   2, -1, 1, 3, 0);   // offset wrap, two refused polls
    do_run("R12", 10,  9,   1, -1, 3, 5, 1);   // stalls, start while busy
    do_run("R6",  20,  6,   0, 12, 1, 0, 0);   // address byte of second chunk refused
    do_run("R6",  40,  5,   0, 3,  2, 2, 0);   // second data byte refused
    do_run("R6",  50,  2,   0, 1,  1, 0, 0);   // first address byte refused
    do_run("R9",  60,  3,   POLL_MAX, -1, 1, 0, 0); // device never answers
    do_run("R5",  0,   256, 0, -1, 1, 0, 0);   // full buffer, no gaps
    do_run("R8",  100, 4,   0, -1, 1, 7, 0);   // exact single chunk, slow data
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL R10 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule